// File: doc/BRIEF.md
# Set-Dueling Insertion Controller

This block keeps a recency ranking for every way of every set in a small cache and decides where a newly filled block enters that ranking. A hit always moves the touched way to the most-recent position. The least-recent way is offered as the victim. On a fill, the block goes either to the head of the ranking, or it stays at the tail, with a rare exception that sends it to the head.

Two insertion schemes compete at run time. A few leader sets are fixed to one scheme each. Their misses move a saturating selector, and the selector's top bit decides which scheme all other sets use. The host cache performs a lookup with the access strobe and the set index, and it reads the victim way while the lookup is in progress. When the refill arrives, it raises the fill strobe with the same set index. Tags, data and miss tracking live outside this block.

Top module: `dip_ctrl`

## Requirements
- R1: After reset every set holds rank w in way w, so the victim of every set is way NUM_WAYS-1, and the selector holds 512, so `follower_bip` reads 1.
- R2: `victim_way` is combinational. It always names the way that holds rank NUM_WAYS-1 (least recent) in the set given by `acc_set`, whatever the strobes are.
- R3: An access with `acc_hit`=1 gives way `acc_way` rank 0. Every way whose rank was below the old rank of that way gains one. All other ranks stay as they were.
- R4: An access with `acc_hit`=0 changes no rank.
- R5: A set whose index modulo 32 is 0 is a head-insertion leader. A set whose index modulo 32 is 1 is a bimodal leader. Every other set is a follower.
- R6: The 10-bit selector adds one on a missing access to a head-insertion leader and subtracts one on a missing access to a bimodal leader. It saturates at 1023 and at 0. `follower_bip` equals selector bit 9.
- R7: A fill into a head-insertion leader moves the victim way to rank 0, and the ranks shift as in R3.
- R8: A fill into a bimodal leader moves the victim way to rank 0 only when the low 5 bits of the 16-bit LFSR are all zero before the fill. Otherwise no rank changes.
- R9: A fill into a follower behaves as in R8 when `follower_bip` is 1, and as in R7 when it is 0.
- R10: `fill_valid` is ignored in any cycle in which `acc_valid` is high: ranks and LFSR are untouched by it.
- R11: The LFSR starts at 16'hACE1. It advances once per accepted fill and at no other time. Each advance shifts left and enters the XOR of bits 15, 13, 12 and 10 as the new bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Lookup strobe |
| acc_set | input | SET_W (6) | Set index for lookups, fills and the victim read |
| acc_hit | input | 1 | Lookup hit when 1 |
| acc_way | input | WAY_W (2) | Way that hit |
| fill_valid | input | 1 | Refill strobe for set `acc_set` |
| victim_way | output | WAY_W (2) | Least-recent way of set `acc_set` |
| follower_bip | output | 1 | 1 when followers use bimodal insertion |

## Verification
The victim output is combinational and is due in the same cycle as the set index. A rank change made by a hit or a fill becomes visible in the victim read of the cycle after the strobe's rising edge. The selector bit likewise reflects a miss one edge later. The bench drives all inputs just after the falling edge and compares both outputs 1 ns later. Its model is updated only after that comparison, so each check sees exactly the state produced by the edges that have already occurred.

// File: rtl/dip_pkg.sv
package dip_pkg;

    typedef enum logic [1:0] {
        ROLE_FOLLOW   = 2'd0,
        ROLE_MRU_LEAD = 2'd1,
        ROLE_BIP_LEAD = 2'd2
    } set_role_e;

    // Leader placement: residue 0 pins head insertion, residue 1 pins bimodal
    function automatic set_role_e role_of(input int unsigned idx, input int unsigned period);
        int unsigned r;
        r = idx % period;
        if (r == 0)      return ROLE_MRU_LEAD;
        else if (r == 1) return ROLE_BIP_LEAD;
        else             return ROLE_FOLLOW;
    endfunction

endpackage

// File: rtl/dip_promote.sv
// Moves one way of a set to rank 0 and ages the ways that were ahead of it.
module dip_promote #(
    parameter int NUM_WAYS = 4,
    localparam int RANK_W  = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic [NUM_WAYS-1:0][RANK_W-1:0] old_vec,
    input  logic                            en,
    input  logic [RANK_W-1:0]               way,
    output logic [NUM_WAYS-1:0][RANK_W-1:0] new_vec
);
    logic [RANK_W-1:0] moved_rank;

    always_comb begin
        moved_rank = old_vec[way];
    end

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        always_comb begin
            if (!en) begin
                new_vec[w] = old_vec[w];
            end else if (RANK_W'(w) == way) begin
                new_vec[w] = '0;
            end else if (old_vec[w] < moved_rank) begin
                new_vec[w] = old_vec[w] + RANK_W'(1);
            end else begin
                new_vec[w] = old_vec[w];
            end
        end
    end

endmodule

// File: rtl/dip_duel_sel.sv
// Saturating duel selector; top bit picks the follower policy.
module dip_duel_sel #(
    parameter int SEL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [SEL_W-1:0] cnt,
    output logic             msb
);
    localparam logic [SEL_W-1:0] SEL_MAX = '1;
    localparam logic [SEL_W-1:0] SEL_MID = SEL_W'(1) << (SEL_W - 1);

    typedef struct packed {
        logic [SEL_W-1:0] cnt;
    } sel_state_t;

    sel_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (inc && !dec && st_q.cnt != SEL_MAX) begin
            st_d.cnt = st_q.cnt + SEL_W'(1);
        end else if (dec && !inc && st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - SEL_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: SEL_MID};
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
    assign msb = st_q.cnt[SEL_W-1];

endmodule

// File: rtl/dip_lfsr.sv
// Fibonacci LFSR stepped once per accepted fill.
module dip_lfsr #(
    parameter int           LFSR_W = 16,
    parameter logic [15:0]  SEED   = 16'hACE1,
    parameter logic [15:0]  TAPS   = 16'hB400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    output logic [LFSR_W-1:0] state
);
    typedef struct packed {
        logic [LFSR_W-1:0] val;
    } lfsr_state_t;

    lfsr_state_t st_d, st_q;
    logic        feedback;

    always_comb begin
        feedback = ^(st_q.val & LFSR_W'(TAPS));
        st_d     = st_q;
        if (step) begin
            st_d.val = {st_q.val[LFSR_W-2:0], feedback};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{val: LFSR_W'(SEED)};
        else        st_q <= st_d;
    end

    assign state = st_q.val;

endmodule

// File: rtl/dip_ctrl.sv
module dip_ctrl
    import dip_pkg::*;
#(
    parameter int NUM_SETS      = 64,
    parameter int NUM_WAYS      = 4,
    parameter int LEADER_PERIOD = 32,
    parameter int SEL_W         = 10,
    parameter int LFSR_W        = 16,
    parameter int ODDS_LOG2     = 5,
    localparam int SET_W        = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
    localparam int WAY_W        = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [SET_W-1:0] acc_set,
    input  logic             acc_hit,
    input  logic [WAY_W-1:0] acc_way,
    input  logic             fill_valid,
    output logic [WAY_W-1:0] victim_way,
    output logic             follower_bip
);
    localparam int RANK_W = WAY_W;

    typedef logic [NUM_WAYS-1:0][RANK_W-1:0] rank_vec_t;

    typedef struct packed {
        rank_vec_t [NUM_SETS-1:0] ranks;
    } dip_state_t;

    function automatic dip_state_t reset_state();
        dip_state_t s;
        for (int i = 0; i < NUM_SETS; i++) begin
            for (int w = 0; w < NUM_WAYS; w++) begin
                s.ranks[i][w] = RANK_W'(w);
            end
        end
        return s;
    endfunction

    dip_state_t          st_d, st_q;
    logic [NUM_SETS-1:0][NUM_WAYS-1:0][RANK_W-1:0] ranks_q;
    rank_vec_t           cur_vec, new_vec;
    logic [WAY_W-1:0]    victim;
    set_role_e           role;
    logic                hit_ev, miss_ev, fill_ev;
    logic                use_bip, lucky, head_fill;
    logic                promo_en;
    logic [WAY_W-1:0]    promo_way;
    logic                sel_inc, sel_dec, sel_msb;
    logic [SEL_W-1:0]    sel_cnt;
    logic [LFSR_W-1:0]   lfsr_state;

    always_comb begin
        cur_vec = st_q.ranks[acc_set];
        victim  = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (cur_vec[w] == RANK_W'(NUM_WAYS - 1)) victim = WAY_W'(w);
        end

        role    = role_of(32'(acc_set), LEADER_PERIOD);
        hit_ev  = acc_valid && acc_hit;
        miss_ev = acc_valid && !acc_hit;
        fill_ev = fill_valid && !acc_valid;

        sel_inc = miss_ev && (role == ROLE_MRU_LEAD);
        sel_dec = miss_ev && (role == ROLE_BIP_LEAD);

        case (role)
            ROLE_MRU_LEAD: use_bip = 1'b0;
            ROLE_BIP_LEAD: use_bip = 1'b1;
            default:       use_bip = sel_msb;
        endcase
        lucky     = (lfsr_state[ODDS_LOG2-1:0] == '0);
        head_fill = fill_ev && (!use_bip || lucky);

        promo_en  = hit_ev || head_fill;
        promo_way = hit_ev ? acc_way : victim;

        st_d = st_q;
        if (promo_en) begin
            st_d.ranks[acc_set] = new_vec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= reset_state();
        else        st_q <= st_d;
    end

    dip_promote #(.NUM_WAYS(NUM_WAYS)) u_promote (
        .old_vec (cur_vec),
        .en      (promo_en),
        .way     (promo_way),
        .new_vec (new_vec)
    );

    dip_duel_sel #(.SEL_W(SEL_W)) u_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (sel_inc),
        .dec   (sel_dec),
        .cnt   (sel_cnt),
        .msb   (sel_msb)
    );

    dip_lfsr #(.LFSR_W(LFSR_W)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (fill_ev),
        .state (lfsr_state)
    );

    assign ranks_q      = st_q.ranks;
    assign victim_way   = victim;
    assign follower_bip = sel_msb;

endmodule

// File: rtl/dip_ctrl_chk.sv
module dip_ctrl_chk
    import dip_pkg::*;
#(
    parameter int NUM_SETS      = 64,
    parameter int NUM_WAYS      = 4,
    parameter int LEADER_PERIOD = 32,
    parameter int SEL_W         = 10,
    parameter int LFSR_W        = 16,
    localparam int SET_W        = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
    localparam int WAY_W        = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_valid,
    input logic [SET_W-1:0] acc_set,
    input logic             acc_hit,
    input logic [WAY_W-1:0] acc_way,
    input logic             fill_valid,
    input logic [WAY_W-1:0] victim_way,
    input logic [NUM_SETS-1:0][NUM_WAYS-1:0][WAY_W-1:0] ranks_q,
    input logic [SEL_W-1:0]  sel_cnt,
    input logic [LFSR_W-1:0] lfsr_state
);
    localparam logic [SEL_W-1:0] SEL_TOP = '1;

    set_role_e        role;
    logic             hit_q, mfill_q;
    logic [SET_W-1:0] hit_set_q, mfill_set_q;
    logic [WAY_W-1:0] hit_way_q, mfill_way_q;

    always_comb role = role_of(32'(acc_set), LEADER_PERIOD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_q <= 1'b0; hit_set_q <= '0; hit_way_q <= '0;
            mfill_q <= 1'b0; mfill_set_q <= '0; mfill_way_q <= '0;
        end else begin
            hit_q       <= acc_valid && acc_hit;
            hit_set_q   <= acc_set;
            hit_way_q   <= acc_way;
            mfill_q     <= fill_valid && !acc_valid && (role == ROLE_MRU_LEAD);
            mfill_set_q <= acc_set;
            mfill_way_q <= victim_way;
        end
    end

    // Exactly one way per set sits at the tail rank (R1 keeps it a permutation)
    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        logic [NUM_WAYS-1:0] tail_mask;
        for (genvar w = 0; w < NUM_WAYS; w++) begin : g_w
            assign tail_mask[w] = (ranks_q[s][w] == WAY_W'(NUM_WAYS - 1));
        end
        p_one_tail_r1: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(tail_mask) == 1);
    end

    p_hit_head_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_q |-> ranks_q[hit_set_q][hit_way_q] == '0);

    p_miss_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_hit) |=> $stable(ranks_q));

    p_mru_fill_head_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mfill_q |-> ranks_q[mfill_set_q][mfill_way_q] == '0);

    p_sel_sat_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_cnt == SEL_TOP && acc_valid && !acc_hit && role == ROLE_MRU_LEAD)
        |=> sel_cnt == SEL_TOP);

    p_sel_sat_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_cnt == '0 && acc_valid && !acc_hit && role == ROLE_BIP_LEAD)
        |=> sel_cnt == '0);

    p_lfsr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_valid && !acc_valid) |=> $stable(lfsr_state));

    p_lfsr_move_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !acc_valid) |=> lfsr_state != $past(lfsr_state));

endmodule

bind dip_ctrl dip_ctrl_chk #(
    .NUM_SETS      (NUM_SETS),
    .NUM_WAYS      (NUM_WAYS),
    .LEADER_PERIOD (LEADER_PERIOD),
    .SEL_W         (SEL_W),
    .LFSR_W        (LFSR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_set    (acc_set),
    .acc_hit    (acc_hit),
    .acc_way    (acc_way),
    .fill_valid (fill_valid),
    .victim_way (victim_way),
    .ranks_q    (ranks_q),
    .sel_cnt    (sel_cnt),
    .lfsr_state (lfsr_state)
);

// File: tb/dip_ctrl_tb.sv
`timescale 1ns/1ps
module dip_ctrl_tb;
    localparam int NS = 64;
    localparam int NW = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0;
    logic [5:0] acc_set = '0;
    logic       acc_hit = 1'b0;
    logic [1:0] acc_way = '0;
    logic       fill_valid = 1'b0;
    logic [1:0] victim_way;
    logic       follower_bip;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    int          mr [NS][NW];
    int          msel;
    logic [15:0] mlfsr;
    string       last_tag = "R1";

    always #2 clk = ~clk;   // 250 MHz

    dip_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
        .acc_hit(acc_hit), .acc_way(acc_way), .fill_valid(fill_valid),
        .victim_way(victim_way), .follower_bip(follower_bip)
    );

    function automatic int mvictim(int s);
        for (int w = 0; w < NW; w++) if (mr[s][w] == NW - 1) return w;
        return -1;
    endfunction

    function automatic void mpromote(int s, int w);
        int old = mr[s][w];
        for (int k = 0; k < NW; k++) if (k != w && mr[s][k] < old) mr[s][k]++;
        mr[s][w] = 0;
    endfunction

    // role per R5: 1 = head leader, 2 = bimodal leader, 0 = follower
    function automatic int mrole(int s);
        if (s % 32 == 0) return 1;
        if (s % 32 == 1) return 2;
        return 0;
    endfunction

    function automatic void mapply(bit av, int s, bit h, int w, bit fv);
        if (av) begin
            if (h) begin mpromote(s, w); last_tag = "R3"; end
            else begin
                if (mrole(s) == 1 && msel < 1023) msel++;
                if (mrole(s) == 2 && msel > 0) msel--;
                last_tag = fv ? "R10" : "R4";
            end
        end else if (fv) begin
            bit bip, head;
            int r = mrole(s);
            bip  = (r == 2) || (r == 0 && msel >= 512);
            head = !bip || (mlfsr[4:0] == 5'd0);
            mlfsr = {mlfsr[14:0], mlfsr[15] ^ mlfsr[13] ^ mlfsr[12] ^ mlfsr[10]};
            if (head) mpromote(s, mvictim(s));
            last_tag = (r == 1) ? "R7" : (r == 2) ? "R8" : "R9";
        end
    endfunction

    task automatic step(bit av, int s, bit h, int w, bit fv, string tag = "");
        @(negedge clk);
        acc_valid = av; acc_set = 6'(s); acc_hit = h; acc_way = 2'(w); fill_valid = fv;
        #1;
        checks++;
        if (int'(victim_way) != mvictim(s)) begin
            errors++;
            $display("FAIL %s victim set %0d got %0d exp %0d", last_tag, s, victim_way, mvictim(s));
        end
        checks++;
        if (follower_bip != (msel >= 512)) begin
            errors++;
            $display("FAIL R6 follower_bip got %0d exp %0d (sel %0d)", follower_bip, msel >= 512, msel);
        end
        mapply(av, s, h, w, fv);
        if (tag != "") last_tag = tag;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++;
                $display("FAIL watchdog expired");
                finish_run();
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int s = 0; s < NS; s++) for (int w = 0; w < NW; w++) mr[s][w] = w;
        msel  = 512;
        mlfsr = 16'hACE1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset ranks and selector midpoint, probed over every set
        for (int s = 0; s < NS; s++) step(0, s, 0, 0, 0);
        last_tag = "R2";

        // R3: hit the tail way of a follower, then a middle way
        step(1, 5, 1, 3, 0);
        step(0, 5, 0, 0, 0);
        step(1, 5, 1, 1, 0);
        step(0, 5, 0, 0, 0);
        // R4: misses without fill leave the order alone
        step(1, 5, 0, 0, 0);
        step(0, 5, 0, 0, 0);
        // R7: head fill in leader set 0
        step(1, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0);
        // R10: fill together with a lookup is dropped
        step(1, 32, 0, 0, 1);
        step(0, 32, 0, 0, 0);

        // R5, R6: drive selector to top saturation and down to zero
        for (int i = 0; i < 600; i++) step(1, (i % 2) ? 32 : 0, 0, 0, 0, "R5");
        for (int i = 0; i < 1100; i++) step(1, (i % 2) ? 33 : 1, 0, 0, 0, "R6");

        // R9: selector low, followers insert at head
        for (int i = 0; i < 8; i++) step(0, 7, 0, 0, 1);
        // raise selector to bimodal for followers
        for (int i = 0; i < 520; i++) step(1, 0, 0, 0, 0);
        for (int i = 0; i < 80; i++) step(0, 9 + (i % 3), 0, 0, 1, "R9");

        // R8, R11: bimodal leader fills, interleaved with dropped fills
        for (int i = 0; i < 100; i++) begin
            step(0, 1, 0, 0, 1, "R8");
            step(1, 33, 1, i % 4, 1, "R11");
            step(0, 33, 0, 0, 1, "R11");
        end

        // constrained random mix, biased toward leader sets
        for (int i = 0; i < 6000; i++) begin
            int  s;
            int  k = int'($urandom_range(0, 9));
            bit  av = ($urandom_range(0, 9) < 6);
            if (k < 2) s = 32 * int'($urandom_range(0, 1));
            else if (k < 4) s = 32 * int'($urandom_range(0, 1)) + 1;
            else s = int'($urandom_range(0, NS - 1));
            step(av, s, bit'($urandom_range(0, 1)), int'($urandom_range(0, NW - 1)),
                 ($urandom_range(0, 3) != 0));
        end
        step(0, 0, 0, 0, 0);
        finish_run();
    end

endmodule